// File: doc/BRIEF.md
# Dynamic-Sizing Memory Responder

This block answers bus cycles addressed to a 32-bit memory port on a processor bus whose transfers may be one, two, three or four bytes wide and need not be aligned. At the start of each cycle it turns the 2-bit size code and the two lowest address bits into four byte-lane enables. The port is big-endian: the top lane holds byte offset 0. It then reads or writes a small internal RAM through those lanes.

Each cycle is ended in one of three ways, chosen by a per-region mode input. The first is a two-bit handshake acknowledge, reported as a full 32-bit port, for a cycle of at least three clocks. The second is a synchronous termination strobe, for a cycle of at least two clocks. The third is a burst: the strobe together with a burst acknowledge moves four long words (one aligned 16-byte line) in at least five clocks. The burst visits the four line slots in wrap-around order from the addressed slot. A burst is granted only for a long-word transfer that asks for one in a burst-capable region. Any other request in such a region is served as a single synchronous transfer.

Top module: `dynsize_mem_slave`

## Requirements
- R1: Lane encoding is lane_en[3] = data[31:24] = offset 0 down to lane_en[0] = data[7:0] = offset 3. Size code 01 is a byte and enables only the lane of the addressed offset. Size code 10 is a word and gives 1100, 0110, 0011 and 0001 for offsets 0 to 3. The enables are valid from the clock after the strobe is first sampled high.
- R2: Size code 11 (three bytes) and 00 (long word) enable every lane from the addressed offset down to lane_en[0]. This gives 1111, 0111, 0011 and 0001 for offsets 0 to 3.
- R3: With term_mode 01 (synchronous), term_stb is high in the clock after the strobe is first sampled high. It stays high while the strobe is held. hs_ack stays 00.
- R4: With term_mode 00 (asynchronous), hs_ack is 00 in the first clock after the strobe is sampled. It becomes 11 (32-bit port) one clock later and stays there while the strobe is held. term_stb stays low.
- R5: With term_mode 10 or 11, burst_req high and size code 00, term_stb and burst_ack are both high for exactly four consecutive clocks, starting in the clock after the strobe is first sampled. Then both go low. Beat i transfers the word at line slot (addr[3:2] + i) mod 4.
- R6: In a burst-capable region, a request whose size is not 00, or that has burst_req low, is served as a single synchronous transfer with burst_ack never high. term_mode 01 never grants a burst.
- R7: A write changes only the RAM bytes whose lanes are enabled. A single write takes wdata at the clock edge that ends the first termination clock. A burst write takes wdata for each beat at the edge that ends that beat.
- R8: Read data appears with the first termination clock, or with each beat for a burst. Lanes that are not enabled read as zero.
- R9: In the clock after the strobe is sampled low, lane_en, hs_ack, term_stb, burst_ack and rdata are all zero.
- R10: While rst_n is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strobe | input | 1 | Address strobe, high for the whole cycle |
| size_code | input | 2 | Transfer size: 01 byte, 10 word, 11 three bytes, 00 long |
| addr | input | ADDR_W | Byte address; [1:0] pick the offset, [3:2] the line slot |
| is_read | input | 1 | 1 = read, 0 = write |
| burst_req | input | 1 | Request for a four-long-word burst |
| term_mode | input | 2 | Region termination mode: 00 async, 01 sync, 1x burst-capable |
| wdata | input | 32 | Write data, big-endian lanes |
| lane_en | output | 4 | Byte-lane enables, bit 3 = data[31:24] |
| hs_ack | output | 2 | Handshake acknowledge, 11 = 32-bit port |
| term_stb | output | 1 | Synchronous termination strobe |
| burst_ack | output | 1 | Burst acknowledge |
| rdata | output | 32 | Read data, disabled lanes zero |

## Verification
Take E1 as the first rising edge that samples the strobe high. Lane enables, read data, term_stb and burst_ack are due in the clock after E1, and hs_ack is due one clock later. Burst beats follow on the next three clocks, and everything clears in the clock after the edge that samples the strobe low. The bench changes inputs and samples outputs only on falling edges. It counts falling edges from the strobe assertion, so each check lands in the exact clock its result is due, and the clock before it is checked where a signal must still be low. Writes are checked by reading the word back through a later cycle and comparing it with a shadow copy kept by the bench.

// File: rtl/dynsize_mem_pkg.sv
package dynsize_mem_pkg;

   typedef enum logic [1:0] {
      SZ_LONG   = 2'b00,
      SZ_BYTE   = 2'b01,
      SZ_WORD   = 2'b10,
      SZ_TRIPLE = 2'b11
   } xfer_size_e;

   typedef enum logic [1:0] {
      TM_ASYNC     = 2'b00,
      TM_SYNC      = 2'b01,
      TM_BURST     = 2'b10,
      TM_BURST_ALT = 2'b11
   } term_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ASYNC,
      ST_HOLD,
      ST_BURST,
      ST_DONE
   } cyc_state_e;

   localparam int unsigned PORT_LANES = 4;
   localparam logic [1:0]  ACK_PORT32 = 2'b11;

endpackage

// File: rtl/dyn_lane_decode.sv
module dyn_lane_decode
   import dynsize_mem_pkg::*;
#(
   parameter int unsigned LANES = 4,
   localparam int unsigned OFF_W = $clog2(LANES)
) (
   input  logic [1:0]       size,
   input  logic [OFF_W-1:0] off,
   output logic [LANES-1:0] lanes
);

   if (LANES != 4) begin : g_bad_lanes
      $error("dyn_lane_decode: size codes cover a four-lane port only");
   end

   // R1 / R2: lane k carries byte offset LANES-1-k (big-endian)
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int P = LANES - 1 - k;
      logic hit_byte, hit_word, hit_tail;
      always_comb begin
         hit_byte = (P == int'(off));
         hit_word = (P >= int'(off)) && (P <= int'(off) + 1);
         hit_tail = (P >= int'(off));
         case (size)
            SZ_BYTE: lanes[k] = hit_byte;
            SZ_WORD: lanes[k] = hit_word;
            default: lanes[k] = hit_tail;
         endcase
      end
   end

endmodule

// File: rtl/dyn_lane_ram.sv
module dyn_lane_ram #(
   parameter int unsigned LANES = 4,
   parameter int unsigned WORDS = 64,
   localparam int unsigned IDX_W = $clog2(WORDS),
   localparam int unsigned DW    = 8 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LANES-1:0] wr_be,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    rd_word
);

   if (WORDS < 4 || WORDS > 4096) begin : g_bad_words
      $error("dyn_lane_ram: WORDS out of supported range");
   end

   // one byte-wide array per lane so a partial write touches only its lanes (R7)
   for (genvar k = 0; k < LANES; k++) begin : g_bank
      logic [7:0] bank [WORDS];

      always_ff @(posedge clk) begin
         if (wr_en && wr_be[k]) begin
            bank[wr_idx] <= wr_data[8*k +: 8];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_word[8*k +: 8] <= '0;
         end else if (rd_en) begin
            rd_word[8*k +: 8] <= bank[rd_idx];
         end
      end
   end

endmodule

// File: rtl/dyn_cycle_fsm.sv
module dyn_cycle_fsm
   import dynsize_mem_pkg::*;
#(
   parameter int unsigned BEATS = 4,
   localparam int unsigned SLOT_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [1:0]        mode,
   input  logic [1:0]        size,
   input  logic              burst_req,
   input  logic              is_read,
   input  logic [SLOT_W-1:0] slot_in,
   output logic              start,
   output logic              burst_sel,
   output logic              burst_on,
   output logic [1:0]        ack,
   output logic              term,
   output logic              back,
   output logic              rd_fire,
   output logic [SLOT_W-1:0] rd_slot,
   output logic              wr_fire,
   output logic [SLOT_W-1:0] wr_slot
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BEATS - 1);
   localparam logic [SLOT_W-1:0] ONE  = SLOT_W'(1);

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("dyn_cycle_fsm: BEATS must be a power of two of at least 2");
   end

   cyc_state_e        state;
   logic [SLOT_W-1:0] beat;
   logic [SLOT_W-1:0] base_slot;
   logic              read_q;
   logic              wr_pend;

   always_comb begin
      start     = (state == ST_IDLE) && strobe;
      // R6: grant only long-word requests in a burst-capable region
      burst_sel = mode[1] && burst_req && (size == SZ_LONG);
      burst_on  = (state == ST_BURST);
      rd_fire   = (start && is_read) ||
                  (burst_on && strobe && read_q && (beat != LAST));
      rd_slot   = start ? slot_in : (base_slot + beat + ONE);
      wr_fire   = !read_q && strobe &&
                  (((state == ST_HOLD) && wr_pend) || burst_on);
      wr_slot   = base_slot + beat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         beat      <= '0;
         base_slot <= '0;
         read_q    <= 1'b1;
         wr_pend   <= 1'b0;
         ack       <= '0;
         term      <= 1'b0;
         back      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (strobe) begin
                  base_slot <= slot_in;
                  beat      <= '0;
                  read_q    <= is_read;
                  wr_pend   <= !is_read;
                  if (mode == TM_ASYNC) begin
                     state <= ST_ASYNC;            // R4
                  end else if (burst_sel) begin
                     state <= ST_BURST;            // R5
                     term  <= 1'b1;
                     back  <= 1'b1;
                  end else begin
                     state <= ST_HOLD;             // R3 / R6
                     term  <= 1'b1;
                  end
               end
            end
            ST_ASYNC: begin
               if (!strobe) begin
                  state <= ST_IDLE;
               end else begin
                  ack   <= ACK_PORT32;
                  state <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               wr_pend <= 1'b0;
               if (!strobe) begin                  // R9
                  ack   <= '0;
                  term  <= 1'b0;
                  state <= ST_IDLE;
               end
            end
            ST_BURST: begin
               if (!strobe) begin
                  term  <= 1'b0;
                  back  <= 1'b0;
                  state <= ST_IDLE;
               end else if (beat == LAST) begin
                  term  <= 1'b0;
                  back  <= 1'b0;
                  state <= ST_DONE;
               end else begin
                  beat <= beat + ONE;
               end
            end
            ST_DONE: begin
               if (!strobe) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dynsize_mem_slave.sv
module dynsize_mem_slave
   import dynsize_mem_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BEATS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_strobe,
   input  logic [1:0]        size_code,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_read,
   input  logic              burst_req,
   input  logic [1:0]        term_mode,
   input  logic [31:0]       wdata,
   output logic [3:0]        lane_en,
   output logic [1:0]        hs_ack,
   output logic              term_stb,
   output logic              burst_ack,
   output logic [31:0]       rdata
);

   localparam int unsigned LANES  = PORT_LANES;
   localparam int unsigned OFF_W  = $clog2(LANES);
   localparam int unsigned SLOT_W = $clog2(BEATS);
   localparam int unsigned IDX_W  = ADDR_W - OFF_W;
   localparam int unsigned LINE_W = IDX_W - SLOT_W;
   localparam int unsigned WORDS  = 1 << IDX_W;

   if (ADDR_W <= OFF_W + SLOT_W || ADDR_W > 14) begin : g_bad_addr
      $error("dynsize_mem_slave: ADDR_W must exceed the line offset bits and stay small");
   end

   logic              start, burst_sel, burst_on;
   logic              rd_fire, wr_fire;
   logic [SLOT_W-1:0] rd_slot, wr_slot;
   logic [LANES-1:0]  dec_lanes;
   logic [LANES-1:0]  lane_q;
   logic [IDX_W-1:0]  word_q;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [31:0]       rd_word;

   dyn_lane_decode #(.LANES(LANES)) u_decode (
      .size  (size_code),
      .off   (addr[OFF_W-1:0]),
      .lanes (dec_lanes)
   );

   dyn_cycle_fsm #(.BEATS(BEATS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (cyc_strobe),
      .mode      (term_mode),
      .size      (size_code),
      .burst_req (burst_req),
      .is_read   (is_read),
      .slot_in   (addr[OFF_W +: SLOT_W]),
      .start     (start),
      .burst_sel (burst_sel),
      .burst_on  (burst_on),
      .ack       (hs_ack),
      .term      (term_stb),
      .back      (burst_ack),
      .rd_fire   (rd_fire),
      .rd_slot   (rd_slot),
      .wr_fire   (wr_fire),
      .wr_slot   (wr_slot)
   );

   // request capture: lanes held for the cycle, cleared once the strobe drops (R9)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q <= '0;
         word_q <= '0;
      end else if (start) begin
         lane_q <= (burst_sel && term_mode != TM_ASYNC) ? '1 : dec_lanes;
         word_q <= addr[ADDR_W-1:OFF_W];
      end else if (!cyc_strobe) begin
         lane_q <= '0;
      end
   end

   // burst beats walk the slots of the line selected at cycle start (R5)
   always_comb begin
      rd_idx = start ? {addr[ADDR_W-1:OFF_W+SLOT_W], rd_slot}
                     : {word_q[IDX_W-1:SLOT_W], rd_slot};
      wr_idx = burst_on ? {word_q[IDX_W-1:SLOT_W], wr_slot} : word_q;
   end

   dyn_lane_ram #(.LANES(LANES), .WORDS(WORDS)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_fire),
      .rd_idx  (rd_idx),
      .wr_en   (wr_fire),
      .wr_idx  (wr_idx),
      .wr_be   (lane_q),
      .wr_data (wdata),
      .rd_word (rd_word)
   );

   assign lane_en = lane_q;

   // R8: lanes outside the transfer read as zero
   for (genvar k = 0; k < LANES; k++) begin : g_mask
      assign rdata[8*k +: 8] = rd_word[8*k +: 8] & {8{lane_q[k]}};
   end

   if (LINE_W < 1) begin : g_bad_line
      $error("dynsize_mem_slave: address too narrow for a line");
   end

endmodule

// File: rtl/dynsize_mem_slave_chk.sv
module dynsize_mem_slave_chk #(
   parameter int unsigned BEATS = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cyc_strobe,
   input logic [1:0] term_mode,
   input logic [3:0] lane_en,
   input logic [1:0] hs_ack,
   input logic       term_stb,
   input logic       burst_ack
);

   logic [7:0] burst_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_run <= '0;
      end else if (burst_ack) begin
         burst_run <= burst_run + 8'd1;
      end else begin
         burst_run <= '0;
      end
   end

   assert_lane_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en inside {4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0001,
                      4'b1100, 4'b0110, 4'b0011, 4'b1111, 4'b0111});

   assert_sync_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cyc_strobe) && term_mode != 2'b00) |=> term_stb);

   assert_async_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cyc_strobe) && term_mode == 2'b00) |=> (hs_ack == 2'b00 && !term_stb));

   assert_ack_port32_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_ack != 2'b00) |-> (hs_ack == 2'b11 && !term_stb && $past(cyc_strobe)));

   assert_burst_with_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_ack |-> term_stb);

   assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_ack |-> (burst_run < 8'(BEATS)));

   assert_negate_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_strobe |=> (hs_ack == 2'b00 && !term_stb && !burst_ack && lane_en == 4'b0000));

endmodule

bind dynsize_mem_slave dynsize_mem_slave_chk #(.BEATS(BEATS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_strobe (cyc_strobe),
   .term_mode  (term_mode),
   .lane_en    (lane_en),
   .hs_ack     (hs_ack),
   .term_stb   (term_stb),
   .burst_ack  (burst_ack)
);

// File: tb/dynsize_mem_slave_test.sv
`timescale 1ns/1ps
module dynsize_mem_slave_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_strobe = 1'b0;
   logic [1:0]  size_code = 2'b00;
   logic [7:0]  addr = '0;
   logic        is_read = 1'b1;
   logic        burst_req = 1'b0;
   logic [1:0]  term_mode = 2'b01;
   logic [31:0] wdata = '0;
   logic [3:0]  lane_en;
   logic [1:0]  hs_ack;
   logic        term_stb;
   logic        burst_ack;
   logic [31:0] rdata;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [1:0] M_ASYNC = 2'b00, M_SYNC = 2'b01, M_BURST = 2'b10;
   localparam logic [1:0] S_LONG = 2'b00, S_BYTE = 2'b01, S_WORD = 2'b10, S_TRI = 2'b11;
   localparam logic [31:0] PAT = 32'hA1B2C3D4;
   localparam logic [31:0] W0 = 32'h1111_0000, W1 = 32'h2222_0101,
                           W2 = 32'h3333_0202, W3 = 32'h4444_0303;

   // {size, offset, expected lanes}
   localparam logic [7:0] VEC [16] = '{
      8'b01_00_1000, 8'b01_01_0100, 8'b01_10_0010, 8'b01_11_0001,
      8'b10_00_1100, 8'b10_01_0110, 8'b10_10_0011, 8'b10_11_0001,
      8'b11_00_1111, 8'b11_01_0111, 8'b11_10_0011, 8'b11_11_0001,
      8'b00_00_1111, 8'b00_01_0111, 8'b00_10_0011, 8'b00_11_0001
   };

   dynsize_mem_slave #(.ADDR_W(8), .BEATS(4)) uut (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .size_code(size_code),
      .addr(addr), .is_read(is_read), .burst_req(burst_req), .term_mode(term_mode),
      .wdata(wdata), .lane_en(lane_en), .hs_ack(hs_ack), .term_stb(term_stb),
      .burst_ack(burst_ack), .rdata(rdata)
   );

   always #10 clk = ~clk;

   function automatic logic [31:0] expand(input logic [3:0] l);
      return {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // called at a falling edge; returns at the falling edge after E1
   task automatic begin_cyc(input logic [1:0] md, input logic [1:0] sz, input logic [7:0] a,
                            input logic rd, input logic br, input logic [31:0] wd);
      term_mode = md; size_code = sz; addr = a; is_read = rd;
      burst_req = br; wdata = wd; cyc_strobe = 1'b1;
      tick();
   endtask

   task automatic end_cyc();
      cyc_strobe = 1'b0;
      burst_req = 1'b0;
      tick();
   endtask

   task automatic sync_write(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] wd);
      begin_cyc(M_SYNC, sz, a, 1'b0, 1'b0, wd);
      tick();
      end_cyc();
   endtask

   task automatic sync_read_long(input logic [7:0] a, output logic [31:0] d);
      begin_cyc(M_SYNC, S_LONG, a, 1'b1, 1'b0, 32'h0);
      d = rdata;
      tick();
      end_cyc();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] got;
      repeat (3) tick();
      // R10: reset state
      chk("R10 lane_en", 32'(lane_en), 32'h0);
      chk("R10 hs_ack", 32'(hs_ack), 32'h0);
      chk("R10 term_stb", 32'(term_stb), 32'h0);
      chk("R10 burst_ack", 32'(burst_ack), 32'h0);
      chk("R10 rdata", rdata, 32'h0);
      rst_n = 1'b1;
      tick();

      // R3: synchronous long write, strobe due in the clock after E1
      begin_cyc(M_SYNC, S_LONG, 8'h10, 1'b0, 1'b0, PAT);
      chk("R3 term_stb", 32'(term_stb), 32'h1);
      chk("R3 hs_ack", 32'(hs_ack), 32'h0);
      tick();
      chk("R3 term_stb held", 32'(term_stb), 32'h1);
      end_cyc();
      chk("R9 term_stb", 32'(term_stb), 32'h0);

      // R1 / R2 / R8: vector table of size and offset
      for (int i = 0; i < 16; i++) begin
         logic [1:0] sz;
         logic [1:0] off;
         logic [3:0] exp_l;
         string tag;
         {sz, off, exp_l} = VEC[i];
         tag = (sz == S_BYTE || sz == S_WORD) ? "R1 lanes" : "R2 lanes";
         begin_cyc(M_SYNC, sz, {6'b000100, off}, 1'b1, 1'b0, 32'h0);
         chk(tag, 32'(lane_en), 32'(exp_l));
         chk("R8 rdata", rdata, PAT & expand(exp_l));
         tick();
         end_cyc();
         chk("R9 lane_en", 32'(lane_en), 32'h0);
         chk("R9 rdata", rdata, 32'h0);
      end

      // R7: byte write at offset 1 touches only data[23:16]
      sync_write(S_BYTE, 8'h11, 32'h5555_5555);
      sync_read_long(8'h10, got);
      chk("R7 byte write", got, 32'hA155_C3D4);

      // R4: asynchronous word write at offset 2
      begin_cyc(M_ASYNC, S_WORD, 8'h12, 1'b0, 1'b0, 32'h0000_BEEF);
      chk("R4 first hs_ack", 32'(hs_ack), 32'h0);
      chk("R4 first term_stb", 32'(term_stb), 32'h0);
      tick();
      chk("R4 hs_ack", 32'(hs_ack), 32'h3);
      chk("R4 term_stb low", 32'(term_stb), 32'h0);
      tick();
      chk("R4 hs_ack held", 32'(hs_ack), 32'h3);
      end_cyc();
      chk("R9 hs_ack", 32'(hs_ack), 32'h0);
      sync_read_long(8'h10, got);
      chk("R7 async word write", got, 32'hA155_BEEF);

      // R4 / R8: asynchronous read
      begin_cyc(M_ASYNC, S_LONG, 8'h10, 1'b1, 1'b0, 32'h0);
      chk("R8 async rdata", rdata, 32'hA155_BEEF);
      tick();
      chk("R4 read hs_ack", 32'(hs_ack), 32'h3);
      end_cyc();

      // R5 / R7: burst write from slot 1 of line 0x20
      begin_cyc(M_BURST, S_LONG, 8'h24, 1'b0, 1'b1, W0);
      chk("R5 beat0 term", 32'(term_stb), 32'h1);
      chk("R5 beat0 back", 32'(burst_ack), 32'h1);
      tick(); wdata = W1;
      chk("R5 beat1 back", 32'(burst_ack), 32'h1);
      tick(); wdata = W2;
      chk("R5 beat2 back", 32'(burst_ack), 32'h1);
      tick(); wdata = W3;
      chk("R5 beat3 term", 32'(term_stb), 32'h1);
      chk("R5 beat3 back", 32'(burst_ack), 32'h1);
      tick();
      chk("R5 after term", 32'(term_stb), 32'h0);
      chk("R5 after back", 32'(burst_ack), 32'h0);
      end_cyc();
      chk("R9 burst lane_en", 32'(lane_en), 32'h0);

      // R5: burst read from slot 2 wraps 2,3,0,1
      begin_cyc(M_BURST, S_LONG, 8'h28, 1'b1, 1'b1, 32'h0);
      chk("R5 rd beat0", rdata, W1);
      chk("R5 rd lanes", 32'(lane_en), 32'hF);
      tick();
      chk("R5 rd beat1", rdata, W2);
      tick();
      chk("R5 rd beat2", rdata, W3);
      tick();
      chk("R5 rd beat3", rdata, W0);
      chk("R5 rd beat3 back", 32'(burst_ack), 32'h1);
      tick();
      chk("R5 rd end back", 32'(burst_ack), 32'h0);
      end_cyc();

      // R6: word request in a burst region falls back to one sync transfer
      begin_cyc(M_BURST, S_WORD, 8'h20, 1'b1, 1'b1, 32'h0);
      chk("R6 word term", 32'(term_stb), 32'h1);
      chk("R6 word back", 32'(burst_ack), 32'h0);
      chk("R6 word rdata", rdata, W3 & 32'hFFFF_0000);
      tick();
      chk("R6 word term held", 32'(term_stb), 32'h1);
      chk("R6 word back held", 32'(burst_ack), 32'h0);
      end_cyc();

      // R6: long without request in burst region
      begin_cyc(M_BURST, S_LONG, 8'h24, 1'b1, 1'b0, 32'h0);
      chk("R6 noreq back", 32'(burst_ack), 32'h0);
      chk("R6 noreq rdata", rdata, W0);
      tick();
      chk("R6 noreq term held", 32'(term_stb), 32'h1);
      end_cyc();

      // R6: sync region never grants a burst
      begin_cyc(M_SYNC, S_LONG, 8'h20, 1'b1, 1'b1, 32'h0);
      chk("R6 sync back", 32'(burst_ack), 32'h0);
      tick();
      chk("R6 sync back later", 32'(burst_ack), 32'h0);
      end_cyc();

      // R2: three-byte write at offset 1 leaves lane 3 alone
      sync_write(S_TRI, 8'h21, 32'hFFEE_DDCC);
      sync_read_long(8'h20, got);
      chk("R2 triple write", got, {W3[31:24], 24'hEEDDCC});

      finish_run();
   end

endmodule